// File: doc/BRIEF.md
# Reloadable Interval Timer with Timestamp

This peripheral combines two counters behind one small register bus. The first is a free-running 32-bit timestamp that advances once per clock. The block's clock is the timer tick, nominally 66.666 MHz. Software can read the timestamp or load a new value into it. The second is a down-counting interval timer. It is set up by a single reload word: the upper thirty bits hold the timeout, and the two lowest bits hold control options. The timeout therefore always has its two least significant bits treated as zero.

The interval timer runs either periodically or as a one-shot. On expiry it raises a pending flag, which drives the interrupt output directly. Software clears the flag by writing a one to its bit position. A second write address, the control alias, changes only the two option bits. This lets software stop or resume the timer without disturbing the stored timeout or the current count.

Register addresses (2-bit word address): 0 timestamp, 1 reload word, 2 control alias (read returns the live down-count), 3 status (bit 0 pending, bit 1 running). Reload word option bits: bit 0 enable, bit 1 one-shot. Reads are combinational from the address.

Top module: `itmr_top`

## Requirements
- R1: The timestamp (address 0) increments by one on every clock and wraps from 0xFFFFFFFF to 0.
- R2: A write to address 0 loads the written word into the timestamp, and counting continues upward from that value on the following clocks.
- R3: A write to address 1 stores the whole word, which reads back at address 1. The same write loads the down-count with the word's bits 31:2 and bits 1:0 forced to zero. The down-count reads back at address 2.
- R4: With reload bit 0 (enable) at zero, the down-count holds its value and status bit 1 (running) reads zero.
- R5: While running, the down-count falls by one per clock. When it reads zero on a clock, that clock is an expiry. Without the one-shot bit (reload bit 1), the expiry reloads the count from the stored timeout, so a timeout of N gives an expiry every N+1 clocks.
- R6: With the one-shot bit set, an expiry leaves the count at zero and clears running, while the stored enable bit stays set. Counting resumes only after a write to address 1 or address 2.
- R7: An expiry sets the pending flag (status bit 0) on the following clock. The output irq equals the pending flag and stays high until cleared.
- R8: Writing status (address 3) with bit 0 set clears pending, and writing it with bit 0 clear has no effect. If an expiry occurs on the same clock as a clearing write, pending stays set.
- R9: A write to address 2 replaces only reload bits 1:0. The stored timeout bits and the current down-count are unchanged.
- R10: After reset the timestamp, reload word, down-count and status all read zero and irq is low.
- R11: On a clock carrying a write to address 1 or 2, the timer neither counts down nor expires, even if the count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for the addressed register |
| busAddr | input | 2 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Interrupt, equal to the pending flag |

## Verification
The hardest situations to reach from the ports are two coincidences: an expiry landing on the same clock as a pending-clear write, and a control write landing on the clock where the count sits at zero. Both depend on exact cycle alignment. The stimulus loads a short timeout of four, idles for exactly the counted number of clocks, and then issues the write on the expiry clock. A behavioural model, advanced on every clock, confirms the alignment independently.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CTRL_W = 2;

  typedef enum logic [1:0] {
    ADDR_TS  = 2'd0,
    ADDR_RLD = 2'd1,
    ADDR_CTL = 2'd2,
    ADDR_STS = 2'd3
  } itmr_addr_e;

  typedef struct packed {
    logic tsLoad;
    logic rldLoad;
    logic ctlLoad;
    logic cntDec;
    logic cntReload;
  } itmr_strobe_t;
endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWr,
  input  logic [1:0]   busAddr,
  input  logic         wBit0,
  input  logic         rldEn,
  input  logic         rldOneShot,
  input  logic         cntZero,
  output itmr_strobe_t strobe,
  output logic         pending,
  output logic         running
);
  logic armed;
  logic wrTs, wrRld, wrCtl, wrSts, busy, expire, stsClr;

  always_comb begin
    wrTs   = busWr && (busAddr == ADDR_TS);
    wrRld  = busWr && (busAddr == ADDR_RLD);
    wrCtl  = busWr && (busAddr == ADDR_CTL);
    wrSts  = busWr && (busAddr == ADDR_STS);
    busy   = wrRld | wrCtl;
    stsClr = wrSts & wBit0;
    running = rldEn & armed;
    expire  = running & cntZero & ~busy;
    strobe.tsLoad    = wrTs;
    strobe.rldLoad   = wrRld;
    strobe.ctlLoad   = wrCtl;
    strobe.cntDec    = running & ~cntZero & ~busy;
    strobe.cntReload = expire & ~rldOneShot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      armed   <= 1'b0;
    end else begin
      pending <= expire | (pending & ~stsClr);
      if (busy)
        armed <= 1'b1;
      else if (expire && rldOneShot)
        armed <= 1'b0;
    end
  end

  // R7: an expiry is always visible as pending one clock later
  assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (running && cntZero && !busy) |=> pending);

  // R8: a clearing write with no expiry drops pending
  assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stsClr && !(running && cntZero && !busy)) |=> !pending);

  // R6: one-shot expiry stops the timer
  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (running && cntZero && rldOneShot && !busy) |=> !running);

  // R11: writes to reload or control re-arm the timer
  assert_write_arms_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> armed);
endmodule

// File: rtl/itmr_datapath.sv
module itmr_datapath
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  itmr_strobe_t      strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [1:0]        busAddr,
  input  logic              pending,
  input  logic              running,
  output logic [DATA_W-1:0] busRdata,
  output logic              rldEn,
  output logic              rldOneShot,
  output logic              cntZero
);
  localparam int TMO_W = DATA_W - CTRL_W;

  logic [DATA_W-1:0] tsCnt;
  logic [DATA_W-1:0] rldReg;
  logic [DATA_W-1:0] downCnt;
  logic [DATA_W-1:0] wrTimeout;
  logic [DATA_W-1:0] storedTimeout;

  assign wrTimeout     = {busWdata[DATA_W-1:CTRL_W], {CTRL_W{1'b0}}};
  assign storedTimeout = {rldReg[DATA_W-1:CTRL_W], {CTRL_W{1'b0}}};
  assign rldEn      = rldReg[0];
  assign rldOneShot = rldReg[1];
  assign cntZero    = (downCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tsCnt <= '0;
    else if (strobe.tsLoad)
      tsCnt <= busWdata;
    else
      tsCnt <= tsCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rldReg <= '0;
    else if (strobe.rldLoad)
      rldReg <= busWdata;
    else if (strobe.ctlLoad)
      rldReg <= {rldReg[DATA_W-1:CTRL_W], busWdata[CTRL_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      downCnt <= '0;
    else if (strobe.rldLoad)
      downCnt <= wrTimeout;
    else if (strobe.cntReload)
      downCnt <= storedTimeout;
    else if (strobe.cntDec)
      downCnt <= downCnt - 1'b1;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_TS:  busRdata = tsCnt;
      ADDR_RLD: busRdata = rldReg;
      ADDR_CTL: busRdata = downCnt;
      default:  busRdata = {{(DATA_W-2){1'b0}}, running, pending};
    endcase
  end

  // R1: timestamp advances by one when not loaded
  assert_ts_count_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tsLoad |=> tsCnt == $past(tsCnt) + 1'b1);

  // R3: a loaded count never carries the option bits
  assert_cnt_align_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rldLoad |=> downCnt[CTRL_W-1:0] == '0);

  // R4: with no strobe the count is frozen
  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntDec || strobe.cntReload || strobe.rldLoad) |=> $stable(downCnt));

  // R9: control alias leaves the timeout bits alone
  assert_ctl_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ctlLoad && !strobe.rldLoad) |=>
      rldReg[DATA_W-1:CTRL_W] == $past(rldReg[DATA_W-1:CTRL_W]));

  // R5: the count leaves zero only by reload or a fresh load
  assert_zero_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && !strobe.rldLoad && !strobe.cntReload) |=> cntZero);

  logic unusedTmo;
  assign unusedTmo = (TMO_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  itmr_strobe_t strobe;
  logic pending, running, rldEn, rldOneShot, cntZero;

  itmr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .wBit0      (busWdata[0]),
    .rldEn      (rldEn),
    .rldOneShot (rldOneShot),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .pending    (pending),
    .running    (running)
  );

  itmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .busAddr    (busAddr),
    .pending    (pending),
    .running    (running),
    .busRdata   (busRdata),
    .rldEn      (rldEn),
    .rldOneShot (rldOneShot),
    .cntZero    (cntZero)
  );

  assign irq = pending;
endmodule

// File: tb/itmr_top_tb.sv
module itmr_top_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, busWr, irq;
  logic [1:0]  busAddr;
  logic [31:0] busWdata, busRdata;

  itmr_top u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mTs, mRld, mCnt;
  logic        mArmed, mPend;
  logic [31:0] lastRd [4];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic probe();
    for (int a = 0; a < 4; a++) begin
      busAddr = a[1:0];
      #1;
      lastRd[a] = busRdata;
    end
    chk("R1 timestamp model", lastRd[0], mTs);
    chk("R3 reload model", lastRd[1], mRld);
    chk("R5 count model", lastRd[2], mCnt);
    chk("R7 status model", lastRd[3], {30'b0, mRld[0] & mArmed, mPend});
    chk("R7 irq model", {31'b0, irq}, {31'b0, mPend});
  endtask

  task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d);
    bit run, busy, ex;
    logic [31:0] nTs, nCnt, nRld;
    logic nArmed, nPend;
    busWr = wr; busAddr = a; busWdata = d;
    @(posedge clk);
    run  = mRld[0] && mArmed;
    busy = wr && (a == 2'd1 || a == 2'd2);
    ex   = run && (mCnt == 32'd0) && !busy;
    nTs  = (wr && a == 2'd0) ? d : mTs + 32'd1;
    nCnt = mCnt;
    if (wr && a == 2'd1) nCnt = d & 32'hFFFF_FFFC;
    else if (ex && !mRld[1]) nCnt = mRld & 32'hFFFF_FFFC;
    else if (run && mCnt != 32'd0 && !busy) nCnt = mCnt - 32'd1;
    nRld = (wr && a == 2'd1) ? d : (wr && a == 2'd2) ? {mRld[31:2], d[1:0]} : mRld;
    nArmed = busy ? 1'b1 : (ex && mRld[1]) ? 1'b0 : mArmed;
    nPend  = ex | (mPend & !(wr && a == 2'd3 && d[0]));
    mTs = nTs; mCnt = nCnt; mRld = nRld; mArmed = nArmed; mPend = nPend;
    #2 busWr = 1'b0;
    @(negedge clk);
    #1 probe();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busWr = 1'b0; busAddr = 2'd0; busWdata = 32'd0;
    mTs = 0; mRld = 0; mCnt = 0; mArmed = 0; mPend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1 probe();
    chk("R10 reset timestamp", lastRd[0], 32'd0);
    chk("R10 reset reload", lastRd[1], 32'd0);
    chk("R10 reset count", lastRd[2], 32'd0);
    chk("R10 reset status", lastRd[3], 32'd0);
    chk("R10 reset irq", {31'b0, irq}, 32'd0);

    step(1'b1, 2'd0, 32'hFFFF_FFFE);
    chk("R2 timestamp load", lastRd[0], 32'hFFFF_FFFE);
    idle(1);
    chk("R2 timestamp continues", lastRd[0], 32'hFFFF_FFFF);
    idle(1);
    chk("R1 timestamp wrap", lastRd[0], 32'd0);

    step(1'b1, 2'd1, 32'h0000_000D);
    chk("R3 reload readback", lastRd[1], 32'h0000_000D);
    chk("R3 count low bits zero", lastRd[2], 32'd12);
    idle(12);
    chk("R5 count reaches zero", lastRd[2], 32'd0);
    chk("R5 no early expiry", {31'b0, irq}, 32'd0);
    idle(1);
    chk("R5 periodic reload", lastRd[2], 32'd12);
    chk("R7 irq on expiry", {31'b0, irq}, 32'd1);

    step(1'b1, 2'd3, 32'd0);
    chk("R8 zero write ignored", {31'b0, irq}, 32'd1);
    step(1'b1, 2'd3, 32'd1);
    chk("R8 write one clears", {31'b0, irq}, 32'd0);

    step(1'b1, 2'd2, 32'd0);
    chk("R9 timeout kept", lastRd[1], 32'h0000_000C);
    chk("R9 count kept", lastRd[2], 32'd10);
    idle(3);
    chk("R4 disabled holds", lastRd[2], 32'd10);
    chk("R4 running clear", lastRd[3], 32'd0);
    step(1'b1, 2'd2, 32'd1);
    idle(1);
    chk("R4 resume counts", lastRd[2], 32'd9);

    step(1'b1, 2'd1, 32'h0000_000B);
    idle(9);
    chk("R6 one-shot expiry status", lastRd[3], 32'd1);
    chk("R6 one-shot stays zero", lastRd[2], 32'd0);
    idle(5);
    chk("R6 stopped count", lastRd[2], 32'd0);
    chk("R6 enable bit kept", lastRd[1], 32'h0000_000B);
    step(1'b1, 2'd3, 32'd1);
    chk("R8 clear after one-shot", {31'b0, irq}, 32'd0);

    step(1'b1, 2'd1, 32'h0000_0005);
    idle(4);
    step(1'b1, 2'd3, 32'd1);
    chk("R8 expiry wins over clear", {31'b0, irq}, 32'd1);
    step(1'b1, 2'd3, 32'd1);
    idle(3);
    step(1'b1, 2'd2, 32'd1);
    chk("R11 no expiry on write", {31'b0, irq}, 32'd0);
    chk("R11 count held at zero", lastRd[2], 32'd0);
    idle(1);
    chk("R11 expiry next clock", {31'b0, irq}, 32'd1);
    chk("R11 reload after", lastRd[2], 32'd4);

    idle(20);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule